// File: doc/BRIEF.md
# Load-Store Dependence Predictor (Store-Set Tables)

This block predicts, at fetch time, whether a load should hold back for an earlier store that is still in flight. Each load and store instruction is mapped by a hashed PC index to an optional dependence-group identifier. Loads and stores that share a group are expected to communicate through memory. A second table records, per group, the instance tag of the youngest fetched store of that group whose address is not yet known. A load whose group has such a store is told to wait for that tag. Any other load is released to run speculatively.

The group table learns from ordering violations. When the memory pipeline reports that a load ran ahead of a store it depended on, the two instructions are placed in one group. A brand new group is allocated when neither has one. The side without a group joins the other's group. When both have groups, both end up in the lower-numbered one. Store address-resolution notices remove a store from its group's pending slot, but only while that slot still names the resolving instance.

Every lookup yields one prediction on the following cycle. Lookups read table state as it stood before any update made in the same cycle.

Top module: `dep_pred_top`

## Requirements
- R1: After reset every group-table entry is invalid, no prediction is presented (`pred_vld` low), and a load lookup is predicted free.
- R2: Each cycle with `look_vld` high produces exactly one cycle of `pred_vld` on the next cycle. No `pred_vld` is produced otherwise.
- R3: A lookup whose PC index has no valid group is predicted free (`pred_wait` = 0).
- R4: A store lookup whose PC index has a valid group records its `look_tag` as the pending store of that group. A store lookup with no valid group records nothing.
- R5: A load lookup whose group has a pending store is predicted to wait (`pred_wait` = 1), with `pred_tag` equal to that store's tag.
- R6: A resolve notice clears its group's pending store only when `res_tag` equals the recorded tag. A notice with any other tag leaves the pending store unchanged.
- R7: A violation in which neither instruction has a group allocates a fresh group to both. Fresh groups are numbered 0, 1, 2, … and wrap modulo 2^SET_W, so successive allocations are distinct.
- R8: A violation in which only one of the two has a group gives that group to the other.
- R9: A violation in which both have different groups moves whichever of the two holds the larger group number into the smaller-numbered group.
- R10: Lookups see the tables as they were before any resolve, violation or store record in the same cycle. When a store record and a matching resolve clear hit the same group in one cycle, the new store's tag is kept.
- R11: A store lookup is also predicted: it waits for the pending store already recorded in its group, reporting that store's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| look_vld | input | 1 | Fetch-time lookup this cycle |
| look_is_store | input | 1 | Lookup is a store (1) or a load (0) |
| look_pc | input | PC_IDX_W | Hashed PC index of the looked-up instruction |
| look_tag | input | TAG_W | Instance tag of a looked-up store |
| res_vld | input | 1 | A store resolved its address |
| res_pc | input | PC_IDX_W | PC index of the resolving store |
| res_tag | input | TAG_W | Instance tag of the resolving store |
| viol_vld | input | 1 | Ordering violation report |
| viol_ld_pc | input | PC_IDX_W | PC index of the violating load |
| viol_st_pc | input | PC_IDX_W | PC index of the store it depended on |
| pred_vld | output | 1 | Prediction valid, one cycle after a lookup |
| pred_wait | output | 1 | Instruction must wait for a pending store |
| pred_tag | output | TAG_W | Tag of the store to wait for (0 when free) |

## Verification
The bench targets the stale-clear case: a resolve with a mismatching tag must leave the pending store alone. A design that cleared on group alone would release a load too early. It walks all four violation-merge cases, including the two directions of a both-valid merge. A design that always overwrote one side, or picked the larger group, would leave a load free where it should wait. It also drives resolve, violation and store-record updates in the same cycle as lookups. A design with write-before-read ordering, or one where a clear beats a fresh store record, would report a wrong tag or a spurious release.

// File: rtl/dep_pred_pkg.sv
package dep_pred_pkg;

  typedef enum logic [2:0] {
    MRG_IDLE,
    MRG_FRESH,
    MRG_JOIN_LD,
    MRG_JOIN_ST,
    MRG_LOWER
  } merge_kind_e;

  function automatic merge_kind_e classify_merge(input logic active,
                                                 input logic ld_has,
                                                 input logic st_has);
    merge_kind_e k;
    if (!active)                 k = MRG_IDLE;
    else if (!ld_has && !st_has) k = MRG_FRESH;
    else if (ld_has && !st_has)  k = MRG_JOIN_LD;
    else if (!ld_has && st_has)  k = MRG_JOIN_ST;
    else                         k = MRG_LOWER;
    return k;
  endfunction

endpackage

// File: rtl/grp_map_table.sv
module grp_map_table #(
  parameter int IDX_W = 6,
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_has,
  output logic [SET_W-1:0] look_grp,
  input  logic [IDX_W-1:0] res_idx,
  output logic             res_has,
  output logic [SET_W-1:0] res_grp,
  input  logic [IDX_W-1:0] ld_idx,
  output logic             ld_has,
  output logic [SET_W-1:0] ld_grp,
  input  logic [IDX_W-1:0] st_idx,
  output logic             st_has,
  output logic [SET_W-1:0] st_grp,
  input  logic             wr_ld_en,
  input  logic             wr_st_en,
  input  logic [SET_W-1:0] wr_grp
);
  localparam int DEPTH = 1 << IDX_W;

  logic             has_q  [DEPTH];
  logic [SET_W-1:0] grp_q  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic wr_en;
    logic has_d;
    logic [SET_W-1:0] grp_d;

    always_comb begin
      wr_en = (wr_ld_en && (ld_idx == IDX_W'(e))) ||
              (wr_st_en && (st_idx == IDX_W'(e)));
      has_d = 1'b1;
      grp_d = wr_grp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        has_q[e] <= 1'b0;
        grp_q[e] <= '0;
      end else if (wr_en) begin
        has_q[e] <= has_d;
        grp_q[e] <= grp_d;
      end
    end
  end

  assign look_has = has_q[look_idx];
  assign look_grp = grp_q[look_idx];
  assign res_has  = has_q[res_idx];
  assign res_grp  = grp_q[res_idx];
  assign ld_has   = has_q[ld_idx];
  assign ld_grp   = grp_q[ld_idx];
  assign st_has   = has_q[st_idx];
  assign st_grp   = grp_q[st_idx];
endmodule

// File: rtl/pending_store_table.sv
module pending_store_table #(
  parameter int SET_W = 4,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_grp,
  output logic             rd_busy,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             rec_en,
  input  logic [SET_W-1:0] rec_grp,
  input  logic [TAG_W-1:0] rec_tag,
  input  logic             clr_en,
  input  logic [SET_W-1:0] clr_grp,
  input  logic [TAG_W-1:0] clr_tag
);
  localparam int GROUPS = 1 << SET_W;

  logic             busy_q [GROUPS];
  logic [TAG_W-1:0] tag_q  [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_slot
    logic rec_hit, clr_hit, en;
    logic busy_d;
    logic [TAG_W-1:0] tag_d;

    always_comb begin
      rec_hit = rec_en && (rec_grp == SET_W'(g));
      clr_hit = clr_en && (clr_grp == SET_W'(g)) && busy_q[g] &&
                (tag_q[g] == clr_tag);
      en      = rec_hit || clr_hit;
      busy_d  = busy_q[g];
      tag_d   = tag_q[g];
      if (rec_hit) begin
        busy_d = 1'b1;
        tag_d  = rec_tag;
      end else if (clr_hit) begin
        busy_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[g] <= 1'b0;
        tag_q[g]  <= '0;
      end else if (en) begin
        busy_q[g] <= busy_d;
        tag_q[g]  <= tag_d;
      end
    end
  end

  assign rd_busy = busy_q[rd_grp];
  assign rd_tag  = tag_q[rd_grp];
endmodule

// File: rtl/viol_merge.sv
module viol_merge
  import dep_pred_pkg::*;
#(
  parameter int SET_W = 4
) (
  input  logic             active,
  input  logic             ld_has,
  input  logic [SET_W-1:0] ld_grp,
  input  logic             st_has,
  input  logic [SET_W-1:0] st_grp,
  input  logic [SET_W-1:0] fresh_grp,
  output logic             wr_ld_en,
  output logic             wr_st_en,
  output logic [SET_W-1:0] wr_grp,
  output logic             take_fresh
);
  merge_kind_e kind;

  always_comb begin
    kind       = classify_merge(active, ld_has, st_has);
    wr_ld_en   = 1'b0;
    wr_st_en   = 1'b0;
    wr_grp     = '0;
    take_fresh = 1'b0;
    unique case (kind)
      MRG_FRESH: begin
        wr_ld_en   = 1'b1;
        wr_st_en   = 1'b1;
        wr_grp     = fresh_grp;
        take_fresh = 1'b1;
      end
      MRG_JOIN_LD: begin
        wr_st_en = 1'b1;
        wr_grp   = ld_grp;
      end
      MRG_JOIN_ST: begin
        wr_ld_en = 1'b1;
        wr_grp   = st_grp;
      end
      MRG_LOWER: begin
        wr_ld_en = ld_grp > st_grp;
        wr_st_en = st_grp > ld_grp;
        wr_grp   = (ld_grp < st_grp) ? ld_grp : st_grp;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dep_pred_top.sv
module dep_pred_top #(
  parameter int PC_IDX_W = 6,
  parameter int SET_W    = 4,
  parameter int TAG_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                look_vld,
  input  logic                look_is_store,
  input  logic [PC_IDX_W-1:0] look_pc,
  input  logic [TAG_W-1:0]    look_tag,
  input  logic                res_vld,
  input  logic [PC_IDX_W-1:0] res_pc,
  input  logic [TAG_W-1:0]    res_tag,
  input  logic                viol_vld,
  input  logic [PC_IDX_W-1:0] viol_ld_pc,
  input  logic [PC_IDX_W-1:0] viol_st_pc,
  output logic                pred_vld,
  output logic                pred_wait,
  output logic [TAG_W-1:0]    pred_tag
);
  logic             lk_has, rs_has, vl_has, vs_has;
  logic [SET_W-1:0] lk_grp, rs_grp, vl_grp, vs_grp;
  logic             wr_ld_en, wr_st_en, take_fresh;
  logic [SET_W-1:0] wr_grp;
  logic             own_busy;
  logic [TAG_W-1:0] own_tag;

  logic [SET_W-1:0] fresh_q, fresh_d;
  logic             pv_q, pv_d, pw_q, pw_d;
  logic [TAG_W-1:0] pt_q, pt_d;

  grp_map_table #(.IDX_W(PC_IDX_W), .SET_W(SET_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .look_idx(look_pc), .look_has(lk_has), .look_grp(lk_grp),
    .res_idx(res_pc),   .res_has(rs_has),  .res_grp(rs_grp),
    .ld_idx(viol_ld_pc), .ld_has(vl_has),  .ld_grp(vl_grp),
    .st_idx(viol_st_pc), .st_has(vs_has),  .st_grp(vs_grp),
    .wr_ld_en(wr_ld_en), .wr_st_en(wr_st_en), .wr_grp(wr_grp)
  );

  pending_store_table #(.SET_W(SET_W), .TAG_W(TAG_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .rd_grp(lk_grp), .rd_busy(own_busy), .rd_tag(own_tag),
    .rec_en(look_vld && look_is_store && lk_has),
    .rec_grp(lk_grp), .rec_tag(look_tag),
    .clr_en(res_vld && rs_has), .clr_grp(rs_grp), .clr_tag(res_tag)
  );

  viol_merge #(.SET_W(SET_W)) u_merge (
    .active(viol_vld),
    .ld_has(vl_has), .ld_grp(vl_grp),
    .st_has(vs_has), .st_grp(vs_grp),
    .fresh_grp(fresh_q),
    .wr_ld_en(wr_ld_en), .wr_st_en(wr_st_en), .wr_grp(wr_grp),
    .take_fresh(take_fresh)
  );

  always_comb begin
    fresh_d = fresh_q + SET_W'(1);
    pv_d    = look_vld;
    pw_d    = lk_has && own_busy;
    pt_d    = (lk_has && own_busy) ? own_tag : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= '0;
    end else if (take_fresh) begin
      fresh_q <= fresh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
    end else begin
      pv_q <= pv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q <= 1'b0;
      pt_q <= '0;
    end else if (look_vld) begin
      pw_q <= pw_d;
      pt_q <= pt_d;
    end
  end

  assign pred_vld  = pv_q;
  assign pred_wait = pw_q && pv_q;
  assign pred_tag  = pv_q ? pt_q : '0;
endmodule

// File: rtl/dep_pred_checker.sv
module dep_pred_checker #(
  parameter int PC_IDX_W = 6,
  parameter int TAG_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                look_vld,
  input logic                look_is_store,
  input logic [PC_IDX_W-1:0] look_pc,
  input logic [TAG_W-1:0]    look_tag,
  input logic                look_id_vld,
  input logic                viol_vld,
  input logic                pred_vld,
  input logic                pred_wait,
  input logic [TAG_W-1:0]    pred_tag
);
  assert_pred_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    look_vld |=> pred_vld);

  assert_no_spurious_pred_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !look_vld |=> !pred_vld);

  assert_wait_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pred_wait |-> pred_vld);

  assert_ungrouped_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (look_vld && !look_id_vld) |=> !pred_wait);

  assert_store_chain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (look_vld && look_is_store &&
     $past(look_vld && look_is_store && look_id_vld && !viol_vld) &&
     look_pc == $past(look_pc))
    |=> (pred_wait && pred_tag == $past(look_tag, 2)));
endmodule

bind dep_pred_top dep_pred_checker #(.PC_IDX_W(PC_IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .look_vld(look_vld), .look_is_store(look_is_store),
  .look_pc(look_pc), .look_tag(look_tag),
  .look_id_vld(lk_has), .viol_vld(viol_vld),
  .pred_vld(pred_vld), .pred_wait(pred_wait), .pred_tag(pred_tag)
);

// File: tb/dep_pred_top_bench.sv
module dep_pred_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 6;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic look_vld = 0, look_is_store = 0;
  logic [PW-1:0] look_pc = '0;
  logic [TW-1:0] look_tag = '0;
  logic res_vld = 0;
  logic [PW-1:0] res_pc = '0;
  logic [TW-1:0] res_tag = '0;
  logic viol_vld = 0;
  logic [PW-1:0] viol_ld_pc = '0, viol_st_pc = '0;
  logic pred_vld, pred_wait;
  logic [TW-1:0] pred_tag;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  typedef struct {
    bit          ew;
    logic [TW-1:0] et;
    string       rid;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dep_pred_top u_dep_pred_top (
    .clk(clk), .rst_n(rst_n),
    .look_vld(look_vld), .look_is_store(look_is_store),
    .look_pc(look_pc), .look_tag(look_tag),
    .res_vld(res_vld), .res_pc(res_pc), .res_tag(res_tag),
    .viol_vld(viol_vld), .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc),
    .pred_vld(pred_vld), .pred_wait(pred_wait), .pred_tag(pred_tag)
  );

  task automatic idle_all();
    look_vld = 0; look_is_store = 0; look_pc = '0; look_tag = '0;
    res_vld = 0; res_pc = '0; res_tag = '0;
    viol_vld = 0; viol_ld_pc = '0; viol_st_pc = '0;
  endtask

  // Called at a negedge; other same-cycle inputs may already be set.
  task automatic look(input bit st, input int pc, input int tag,
                      input bit ew, input int et, input string rid);
    exp_t e;
    look_vld = 1; look_is_store = st; look_pc = PW'(pc); look_tag = TW'(tag);
    e.ew = ew; e.et = TW'(et); e.rid = rid;
    sb.push_back(e);
    @(negedge clk);
    idle_all();
  endtask

  task automatic viol(input int ld, input int st);
    viol_vld = 1; viol_ld_pc = PW'(ld); viol_st_pc = PW'(st);
    @(negedge clk);
    idle_all();
  endtask

  task automatic resolve(input int pc, input int tag);
    res_vld = 1; res_pc = PW'(pc); res_tag = TW'(tag);
    @(negedge clk);
    idle_all();
  endtask

  // Monitor: pops one expectation per prediction.
  always @(negedge clk) begin
    if (rst_n && pred_vld) begin
      if (sb.size() == 0) begin
        vectors++; misses++;
        $display("FAIL R2: pred_vld=1 with no lookup pending, expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        vectors++;
        if (pred_wait !== e.ew || (e.ew && pred_tag !== e.et)) begin
          misses++;
          $display("FAIL %s: wait=%0b tag=%0d, expected wait=%0b tag=%0d",
                   e.rid, pred_wait, pred_tag, e.ew, e.et);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (pred_vld !== 1'b0 || pred_wait !== 1'b0) begin
      misses++;
      $display("FAIL R1: pred_vld=%0b pred_wait=%0b, expected 0 0", pred_vld, pred_wait);
    end
    look(0, 5, 0, 0, 0, "R1");            // fresh load free
    look(0, 6, 0, 0, 0, "R3");            // ungrouped load free
    look(1, 50, 20, 0, 0, "R4");          // ungrouped store records nothing
    viol(5, 9);                            // R7: fresh group 0
    look(1, 9, 3, 0, 0, "R11");           // no earlier pending store
    look(0, 5, 0, 1, 3, "R5");
    look(0, 5, 0, 1, 3, "R4");
    resolve(9, 7);                         // R6 mismatch
    look(0, 5, 0, 1, 3, "R6");
    resolve(9, 3);                         // R6 match
    look(0, 5, 0, 0, 0, "R6");
    look(1, 9, 10, 0, 0, "R11");
    look(1, 9, 11, 1, 10, "R11");
    look(0, 5, 0, 1, 11, "R5");
    viol(20, 30);                          // R7: fresh group 1
    look(1, 30, 12, 0, 0, "R7");
    look(0, 20, 0, 1, 12, "R7");
    look(0, 5, 0, 1, 11, "R7");
    viol(21, 9);                           // R8: load joins store's group
    look(0, 21, 0, 1, 11, "R8");
    viol(5, 31);                           // R8: store joins load's group
    look(1, 31, 13, 1, 11, "R8");
    look(0, 5, 0, 1, 13, "R8");
    viol(20, 9);                           // R9: load moves 1 -> 0
    look(0, 20, 0, 1, 13, "R9");
    viol(5, 30);                           // R9: store moves 1 -> 0
    look(1, 30, 14, 1, 13, "R9");
    look(0, 5, 0, 1, 14, "R9");
    look(0, 21, 0, 1, 14, "R9");
    res_vld = 1; res_pc = 6'd30; res_tag = 6'd14;   // R10 record beats clear
    look(1, 9, 15, 1, 14, "R10");
    look(0, 5, 0, 1, 15, "R10");
    res_vld = 1; res_pc = 6'd9; res_tag = 6'd15;    // R10 lookup sees old state
    look(0, 5, 0, 1, 15, "R10");
    look(0, 5, 0, 0, 0, "R10");
    viol_vld = 1; viol_ld_pc = 6'd40; viol_st_pc = 6'd41;
    look(0, 40, 0, 0, 0, "R10");
    look(1, 41, 16, 0, 0, "R7");          // fresh group 2 empty
    look(0, 40, 0, 1, 16, "R7");
    repeat (3) @(negedge clk);
    vectors++;
    if (sb.size() != 0) begin
      misses++;
      $display("FAIL R2: %0d predictions missing, expected 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule